// File: doc/BRIEF.md
# Step Attenuator Thermometer Controller

This block turns an 8-bit gain control byte and an asynchronous fast-attack request into the segment-enable vector of a digital step attenuator. One segment stands for 0.5 dB. The six low bits of the byte set the programmed attenuation, and values past the floor are clamped to it. The two high bits choose an extra step that is added only while fast attack is active. The step is removed again when the request drops.

The total attenuation count is decoded into a thermometer vector, so the set segments always run from bit 0 upward. The vector is registered so that every segment changes on the same clock edge. The fast-attack pin passes through a two-flop synchronizer. A low enable drives every segment on and raises a power-down flag. Operation resumes on the first clock edge after enable returns high.

Top module: `step_atten_ctrl`

## Requirements
- R1: While rst_ni is low, therm_o is all ones and pdn_o is 1.
- R2: With enable_i high and fast attack inactive, the edge after ctrl_i is applied sets therm_o to exactly N low ones, where N = ctrl_i[5:0] (half-dB units, code 0 is no attenuation).
- R3: Codes 41 to 63 in ctrl_i[5:0] are clamped to 40, the floor of the programmed range.
- R4: While fast attack is active, N gains an extra step chosen by ctrl_i[7:6]: 00 adds 4, 01 adds 8, 10 adds 16, 11 adds 32. The largest total is 72, the width of therm_o.
- R5: therm_o is always a thermometer code: no set bit lies above a clear bit.
- R6: A change on fast_i, held stable, appears in therm_o on the third rising clock edge after it, and not on the second.
- R7: On each edge with enable_i low, therm_o becomes all ones and pdn_o becomes 1, whatever ctrl_i and fast_i do.
- R8: On the first edge with enable_i high, pdn_o clears and therm_o shows the normal level.
- R9: A new ctrl_i applied while fast attack is active takes effect on the next edge, with the selected step added to the new clamped code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | High for normal operation, low for power-down |
| ctrl_i | input | 8 | Gain control byte: [5:0] attenuation code, [7:6] fast-attack step select |
| fast_i | input | 1 | Asynchronous fast-attack request, active high |
| therm_o | output | 72 | Registered thermometer segment enables, bit i on means segment i is in |
| pdn_o | output | 1 | Power-down flag |

## Verification
The assertions assume that ctrl_i is synchronous to clk_i. The fast-attack request may arrive at any time, so the bounds on the segment count only bracket it between the bare clamped code and the code plus the step selected in the same cycle. The stimulus changes ctrl_i, enable_i and fast_i only at falling edges. It holds fast_i stable for at least three edges before it samples a fast-attack result, so the synchronizer delay is counted exactly rather than estimated.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;
  localparam int unsigned CODE_W    = 6;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned CODE_MAX  = 40;
  localparam int unsigned STEP_BASE = 4;
  localparam int unsigned CTRL_W    = CODE_W + SEL_W;
  localparam int unsigned STEP_MAX  = STEP_BASE << ((1 << SEL_W) - 1);
  localparam int unsigned THERM_W   = CODE_MAX + STEP_MAX;
  localparam int unsigned LVL_W     = $clog2(THERM_W + 1);
endpackage

// File: rtl/fa_sync.sv
module fa_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/atten_sum.sv
module atten_sum
  import step_atten_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              fa_i,
  output logic [LVL_W-1:0]  lvl_o
);
  logic [LVL_W-1:0] sat, step;

  always_comb begin
    sat   = (int'(code_i) > int'(CODE_MAX)) ? LVL_W'(CODE_MAX) : LVL_W'(code_i);
    step  = fa_i ? LVL_W'(STEP_BASE << sel_i) : '0;
    lvl_o = sat + step;
  end
endmodule

// File: rtl/therm_enc.sv
module therm_enc #(
  parameter int unsigned LVL_W   = 7,
  parameter int unsigned THERM_W = 72
) (
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [THERM_W-1:0] therm_o
);
  for (genvar i = 0; i < THERM_W; i++) begin : g_seg
    assign therm_o[i] = (lvl_i > LVL_W'(i));
  end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import step_atten_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [CTRL_W-1:0]  ctrl_i,
  input  logic               fast_i,
  output logic [THERM_W-1:0] therm_o,
  output logic               pdn_o
);
  logic               fa_sync_q;
  logic [LVL_W-1:0]   lvl;
  logic [THERM_W-1:0] therm_d, therm_q;
  logic               pdn_q;

  fa_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fast_i),
    .q_o   (fa_sync_q)
  );

  atten_sum u_sum (
    .code_i(ctrl_i[CODE_W-1:0]),
    .sel_i (ctrl_i[CTRL_W-1:CODE_W]),
    .fa_i  (fa_sync_q),
    .lvl_o (lvl)
  );

  therm_enc #(.LVL_W(LVL_W), .THERM_W(THERM_W)) u_enc (
    .lvl_i  (lvl),
    .therm_o(therm_d)
  );

  // single register stage: all segments switch on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      therm_q <= '1;
      pdn_q   <= 1'b1;
    end else if (!enable_i) begin
      therm_q <= '1;
      pdn_q   <= 1'b1;
    end else begin
      therm_q <= therm_d;
      pdn_q   <= 1'b0;
    end
  end

  assign therm_o = therm_q;
  assign pdn_o   = pdn_q;
endmodule

// File: rtl/step_atten_chk.sv
module step_atten_chk
  import step_atten_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic [CTRL_W-1:0]  ctrl_i,
  input logic [THERM_W-1:0] therm_o,
  input logic               pdn_o
);
  function automatic int sat_of(logic [CTRL_W-1:0] c);
    return (int'(c[CODE_W-1:0]) > int'(CODE_MAX)) ? int'(CODE_MAX) : int'(c[CODE_W-1:0]);
  endfunction

  p_therm_shape_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm_o + THERM_W'(1)) & therm_o) == '0);

  p_pdn_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (pdn_o && (&therm_o)));

  p_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> !pdn_o);

  p_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> int'($countones(therm_o)) >= sat_of($past(ctrl_i)));

  p_ceiling_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> int'($countones(therm_o)) <=
      sat_of($past(ctrl_i)) + int'(STEP_BASE << $past(ctrl_i[CTRL_W-1:CODE_W])));
endmodule

bind step_atten_ctrl step_atten_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .enable_i(enable_i),
  .ctrl_i  (ctrl_i),
  .therm_o (therm_o),
  .pdn_o   (pdn_o)
);

// File: tb/tb_step_atten_ctrl.sv
module tb_step_atten_ctrl;
  localparam int TW = 72;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          enable_i = 0;
  logic [7:0]    ctrl_i = '0;
  logic          fast_i = 0;
  logic [TW-1:0] therm_o;
  logic          pdn_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  step_atten_ctrl dut (.*);

  function automatic logic [TW-1:0] therm_of(int n);
    logic [TW-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk_vec(string req, logic [TW-1:0] exp);
    n_chk++;
    if (therm_o !== exp) begin
      n_fail++;
      $display("FAIL %s therm_o act=%h exp=%h", req, therm_o, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pdn_o act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    wait_n(2);
    chk_vec("R1", '1);
    chk_bit("R1", pdn_o, 1'b1);
    rst_ni = 1; enable_i = 1;
    wait_n(1);
    chk_bit("R8", pdn_o, 1'b0);
    chk_vec("R2", therm_of(0));
  endtask

  task automatic t_codes();
    int codes[4] = '{1, 17, 39, 40};
    foreach (codes[k]) begin
      ctrl_i = 8'(codes[k]);
      wait_n(1);
      chk_vec("R2", therm_of(codes[k]));  // R5 shape via full vector
    end
  endtask

  task automatic t_sat();
    int codes[3] = '{41, 50, 63};
    foreach (codes[k]) begin
      ctrl_i = 8'(codes[k]) | 8'hC0;  // fast low: select bits have no effect
      wait_n(1);
      chk_vec("R3", therm_of(40));
    end
  endtask

  task automatic t_steps();
    for (int s = 0; s < 4; s++) begin
      ctrl_i = {2'(s), 6'd10};
      wait_n(1);
      chk_vec("R4", therm_of(10));
      fast_i = 1;
      wait_n(2);
      chk_vec("R6", therm_of(10));
      wait_n(1);
      chk_vec("R4", therm_of(10 + (4 << s)));
      fast_i = 0;
      wait_n(2);
      chk_vec("R6", therm_of(10 + (4 << s)));
      wait_n(1);
      chk_vec("R6", therm_of(10));
    end
  endtask

  task automatic t_update_fa();
    ctrl_i = {2'b01, 6'd5};
    fast_i = 1;
    wait_n(3);
    chk_vec("R9", therm_of(13));
    ctrl_i = {2'b11, 6'd60};
    wait_n(1);
    chk_vec("R9", therm_of(72));
    ctrl_i = {2'b10, 6'd0};
    wait_n(1);
    chk_vec("R9", therm_of(16));
    fast_i = 0;
    wait_n(3);
    chk_vec("R9", therm_of(0));
  endtask

  task automatic t_power();
    ctrl_i = 8'd7;
    wait_n(1);
    enable_i = 0;
    wait_n(1);
    chk_vec("R7", '1);
    chk_bit("R7", pdn_o, 1'b1);
    ctrl_i = 8'd2;
    fast_i = 1;
    wait_n(4);
    chk_vec("R7", '1);
    chk_bit("R7", pdn_o, 1'b1);
    enable_i = 1;
    wait_n(1);
    chk_bit("R8", pdn_o, 1'b0);
    chk_vec("R8", therm_of(6));
    fast_i = 0;
    wait_n(3);
    chk_vec("R8", therm_of(2));
  endtask

  initial begin
    t_reset();
    t_codes();
    t_sat();
    t_steps();
    t_update_fa();
    t_power();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule